// File: doc/BRIEF.md
# Keyswitch Start-Latch Controller

This block turns two raw keyswitch levels into the start-latch level that launches a fixed message transmitter. A reset key sets the latch once its level has stayed pressed for a debounce window, so contact-bounce spikes are rejected. A test key drives an active-low print-test request while it is pressed. When it is released, a timed pulse starts and sets the latch.

The latch cannot be cleared just because a key has dropped. Clearing waits until the transmitter reports that its sequence has ended and no longer asks for the latch to be held. It also waits until no trigger is active, meaning the reset key is not held and the release pulse has expired. A key action that arrives while the latch is already set is ignored, so the launch sequence does not retrigger. Both windows are counted in system-clock cycles, and both raw keys pass through two-flop synchronizers.

Top module: `start_latch_ctrl`

## Requirements
- R1: While rst_n is sampled low, start_latch goes to 0 and print_test_n goes to 1. After reset, with all inputs idle, both outputs keep those values.
- R2: A reset_key level (1 = pressed) that stays high for DEB_CYC consecutive synchronized cycles sets start_latch. The latch rises on the (DEB_CYC+3)-th rising edge after the key rises.
- R3: reset_key high pulses shorter than DEB_CYC cycles, separated by low gaps, never set start_latch.
- R4: print_test_n is 0 while test_key (1 = pressed) is high. It follows the key with a latency of two rising edges.
- R5: A test_key release starts a pulse that is active for PULSE_CYC cycles. The pulse sets start_latch on the 4th rising edge after the release.
- R6: While seq_hold is 1, a set start_latch does not clear, even when seq_done is 1 and no trigger is active.
- R7: A set start_latch clears on the next edge only when seq_done is 1, seq_hold is 0 and no trigger is active. With seq_done at 0 it stays set.
- R8: If reset_key is still held when seq_done arrives, start_latch stays set until the key is released. It then clears on the 4th rising edge after the release.
- R9: If the release pulse is still running when seq_done arrives, start_latch stays set until the pulse expires. It clears on rising edge PULSE_CYC+4 after the release.
- R10: A test_key release while start_latch is set does not start the pulse. The latch then clears as soon as the other clear conditions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_key | input | 1 | Raw reset keyswitch level, 1 = pressed |
| test_key | input | 1 | Raw test keyswitch level, 1 = pressed |
| seq_hold | input | 1 | Transmitter request to keep the latch set |
| seq_done | input | 1 | Transmitter end-of-sequence flag |
| start_latch | output | 1 | Start-latch level that launches the transmitter |
| print_test_n | output | 1 | Active-low print-test request |

## Verification
The hardest case to reach is a test-key release that arrives while the latch is already set. Because the pulse is suppressed, it leaves nothing to see except that the pulse does not extend the latch. To reach it, the stimulus first sets the latch with the reset key and raises seq_hold. It then presses and releases the test key, and only afterwards raises seq_done and releases the reset key. A latch that clears exactly four edges later shows that no pulse was started. A retriggered pulse would keep the latch set for the full pulse length.

// File: rtl/slc_pkg.sv
// Package: shared index constants for the keyswitch start-latch controller.
// Assumes: key vectors are ordered with the reset key at bit 0.
package slc_pkg;
    localparam int NUM_KEYS  = 2;
    localparam int IDX_RESET = 0;
    localparam int IDX_TEST  = 1;
endpackage

// File: rtl/slc_sync.sv
// Module: two-flop synchronizer, one chain per bit of a key vector.
// Assumes: inputs are asynchronous levels; a reset value of 0 means "not pressed".
module slc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    for (genvar i = 0; i < W; i++) begin : g_chain
        logic meta;
        // Two-stage capture of one raw key level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta      <= 1'b0;
                synced[i] <= 1'b0;
            end else begin
                meta      <= raw[i];
                synced[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/slc_debounce.sv
// Module: reset-key qualifier. The held flag rises after DEB_CYC consecutive
// high cycles and drops on the first cycle the synchronized key is low.
// Assumes: key_s is already synchronized to clk.
module slc_debounce #(
    parameter int DEB_CYC = 250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_s,
    output logic held
);
    localparam int CW = $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    logic [CW-1:0] cnt;

    // Count stable-high cycles; any low cycle restarts the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !key_s) begin
            cnt  <= '0;
            held <= 1'b0;
        end else if (!held) begin
            if (cnt == LAST) held <= 1'b1;
            else             cnt  <= cnt + 1'b1;
        end
    end

    // R2: held can only rise after the key was seen high.
    a_r2_held_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(key_s));
endmodule

// File: rtl/slc_release_timer.sv
// Module: release-triggered timer. A falling edge of the synchronized test key,
// when load_en is high, starts a pulse lasting PULSE_CYC cycles.
// Assumes: key_s is synchronized; load_en is low whenever a restart is unwanted.
module slc_release_timer #(
    parameter int PULSE_CYC = 3_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_s,
    input  logic load_en,
    output logic active
);
    localparam int TW = $clog2(PULSE_CYC + 1);

    logic          key_d;
    logic [TW-1:0] remain;
    logic          fall;

    assign fall   = key_d && !key_s;
    assign active = (remain != '0);

    // Delay the key one cycle for release detection.
    always_ff @(posedge clk) begin
        if (!rst_n) key_d <= 1'b0;
        else        key_d <= key_s;
    end

    // Load the pulse length on an enabled release, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                remain <= '0;
        else if (fall && load_en)  remain <= TW'(PULSE_CYC);
        else if (remain != '0)     remain <= remain - 1'b1;
    end

    // R5: the pulse only starts from an enabled release.
    a_r5_pulse_from_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(fall && load_en));
endmodule

// File: rtl/start_latch_ctrl.sv
// Module: keyswitch start-latch controller (top). It sets the start latch from
// the debounced reset key or the test-key release pulse. It clears the latch only
// when the transmitter has finished, is not holding, and no trigger is active.
// Assumes: seq_hold and seq_done are synchronous to clk.
module start_latch_ctrl
    import slc_pkg::*;
#(
    parameter int DEB_CYC   = 250_000,
    parameter int PULSE_CYC = 3_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_key,
    input  logic test_key,
    input  logic seq_hold,
    input  logic seq_done,
    output logic start_latch,
    output logic print_test_n
);
    logic [NUM_KEYS-1:0] raw_keys;
    logic [NUM_KEYS-1:0] sync_keys;
    logic                rst_held;
    logic                pulse_active;
    logic                trig_active;
    logic                clear_ok;

    assign raw_keys[IDX_RESET] = reset_key;
    assign raw_keys[IDX_TEST]  = test_key;

    slc_sync #(.W(NUM_KEYS)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw_keys), .synced(sync_keys)
    );

    slc_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk(clk), .rst_n(rst_n), .key_s(sync_keys[IDX_RESET]), .held(rst_held)
    );

    slc_release_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .key_s(sync_keys[IDX_TEST]),
        .load_en(!start_latch), .active(pulse_active)
    );

    assign trig_active  = rst_held || pulse_active;
    assign clear_ok     = seq_done && !seq_hold && !trig_active;
    assign print_test_n = !sync_keys[IDX_TEST];

    // Start latch: set by any trigger when clear, cleared only under clear_ok.
    always_ff @(posedge clk) begin
        if (!rst_n)                     start_latch <= 1'b0;
        else if (!start_latch)          start_latch <= trig_active;
        else if (clear_ok)              start_latch <= 1'b0;
    end

    // R6: a hold request keeps the latch set.
    a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (start_latch && seq_hold) |=> start_latch);
    // R8 / R9: an active trigger keeps the latch set.
    a_r8_trig_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (start_latch && trig_active) |=> start_latch);
    // R7: a clear happens only after end-of-sequence without hold.
    a_r7_clear_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_latch) |-> $past(seq_done && !seq_hold));
    // R10: the release pulse never starts while the latch is set.
    a_r10_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        start_latch |=> !$rose(pulse_active));
endmodule

// File: tb/tb_start_latch_ctrl.sv
module tb_start_latch_ctrl;
    localparam int DEB   = 8;
    localparam int PULSE = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_key = 1'b0, test_key = 1'b0, seq_hold = 1'b0, seq_done = 1'b0;
    logic start_latch, print_test_n;
    int   checks = 0;
    int   errors = 0;

    start_latch_ctrl #(.DEB_CYC(DEB), .PULSE_CYC(PULSE)) dut (
        .clk(clk), .rst_n(rst_n), .reset_key(reset_key), .test_key(test_key),
        .seq_hold(seq_hold), .seq_done(seq_done),
        .start_latch(start_latch), .print_test_n(print_test_n)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic rk, tk, hold, done;
        int   waitn;
        logic exp_latch, exp_ptn;
        int   req;
    } vec_t;

    // Reset key held past end-of-sequence (R2, R6, R8).
    localparam vec_t VEC [6] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 10, 1'b0, 1'b1, 2},
        '{1'b1, 1'b0, 1'b0, 1'b0,  1, 1'b1, 1'b1, 2},
        '{1'b1, 1'b0, 1'b1, 1'b1,  5, 1'b1, 1'b1, 6},
        '{1'b1, 1'b0, 1'b0, 1'b1, 20, 1'b1, 1'b1, 8},
        '{1'b0, 1'b0, 1'b0, 1'b1,  3, 1'b1, 1'b1, 8},
        '{1'b0, 1'b0, 1'b0, 1'b1,  1, 1'b0, 1'b1, 8}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        check("R1", "latch in reset", start_latch, 1'b0);
        check("R1", "ptn in reset", print_test_n, 1'b1);
        rst_n = 1'b1;
        step(5);
        check("R1", "latch idle", start_latch, 1'b0);

        for (int i = 0; i < 6; i++) begin
            reset_key = VEC[i].rk; test_key = VEC[i].tk;
            seq_hold = VEC[i].hold; seq_done = VEC[i].done;
            step(VEC[i].waitn);
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d latch", i),
                  start_latch, VEC[i].exp_latch);
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d ptn", i),
                  print_test_n, VEC[i].exp_ptn);
        end

        // R3: bouncing reset key, pulses shorter than the window.
        seq_done = 1'b0;
        for (int b = 0; b < 4; b++) begin
            reset_key = 1'b1; step(5);
            reset_key = 1'b0; step(2);
        end
        step(12);
        check("R3", "bounce rejected", start_latch, 1'b0);

        // R4: print-test request follows the key after two edges.
        seq_done = 1'b1;
        test_key = 1'b1;
        step(1);
        check("R4", "ptn before latency", print_test_n, 1'b1);
        step(1);
        check("R4", "ptn asserted", print_test_n, 1'b0);
        step(6);
        check("R4", "no latch while pressed", start_latch, 1'b0);

        // R5 / R9: release pulse sets the latch, then holds it until expiry.
        test_key = 1'b0;
        step(2);
        check("R4", "ptn released", print_test_n, 1'b1);
        step(1);
        check("R5", "latch before edge 4", start_latch, 1'b0);
        step(1);
        check("R5", "latch at edge 4", start_latch, 1'b1);
        step(39);
        check("R9", "latch during pulse", start_latch, 1'b1);
        step(1);
        check("R9", "latch after pulse", start_latch, 1'b0);

        // R6 / R7: hold blocks the clear; dropping hold clears next edge.
        seq_done = 1'b0;
        reset_key = 1'b1;
        step(DEB + 3);
        check("R2", "latch set again", start_latch, 1'b1);
        reset_key = 1'b0;
        step(10);
        check("R7", "no clear without done", start_latch, 1'b1);
        seq_hold = 1'b1; seq_done = 1'b1;
        step(10);
        check("R6", "hold keeps latch", start_latch, 1'b1);
        seq_hold = 1'b0;
        step(1);
        check("R7", "clear on next edge", start_latch, 1'b0);

        // R10: a release while set does not start the pulse.
        seq_done = 1'b0;
        reset_key = 1'b1;
        step(DEB + 3);
        check("R10", "latch set by reset key", start_latch, 1'b1);
        seq_hold = 1'b1;
        test_key = 1'b1; step(4);
        test_key = 1'b0; step(6);
        seq_hold = 1'b0; seq_done = 1'b1; reset_key = 1'b0;
        step(3);
        check("R10", "latch before key drop seen", start_latch, 1'b1);
        step(1);
        check("R10", "latch clears without pulse", start_latch, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule